// File: doc/BRIEF.md
# Serial Three-Wire Configuration Port

This block is the write-only configuration front end of a stereo audio converter. A host shifts 16-bit command words in over a control clock and a data line, then strobes a latch line low. The latch is resynchronised into the system-clock domain. Its falling edge moves the shifted word into one of four configuration registers, chosen by a two-bit address in the middle of the word. The registers drive static settings to the audio datapath: a per-channel attenuation code, soft mute, de-emphasis select, output disable, zero-detect enable, and the serial input format with its output channel mode.

Each attenuation channel is double buffered. A write stores a pending code. The code reaches the datapath only when a write to either attenuation register carries its load bit. The load then applies both pending codes together, so left and right change in the same clock. An active-low reset forces every output to its default and shuts the port off. After reset is released, writes are refused for a fixed number of system clocks.

Top module: `tw_ctrl_port`

## Requirements
- R1: The data line is sampled on each rising control-clock edge and shifted in most significant bit first. Only the last 16 bits shifted before the latch falls form the command word; any earlier bits are discarded.
- R2: Word bits 10:9 select the target register: 0 is left attenuation, 1 is right attenuation, 2 is mode, 3 is format. Bits 15:11 are reserved and have no effect on the result.
- R3: The latch line is sampled by two synchroniser stages in the system-clock domain. Each falling edge causes exactly one update, no matter how long the latch stays low. That update is visible at the outputs after the third rising system-clock edge following the latch going low. Outputs never change without a latch edge.
- R4: A write to register 0 or 1 stores bits 7:0 as that channel's pending code. If bit 8 (the load bit) is 1, both pending codes, including the one just written, become the active codes in the same cycle. Otherwise the active codes `att_left` and `att_right` are unchanged.
- R5: A write to register 2 sets `soft_mute` from bit 0, `deemph_sel` from bits 2:1, `out_disable` from bit 3 and `zero_det_en` from bit 4.
- R6: A write to register 3 sets `fmt_i2s` from bit 0, `lr_swap` from bit 1, `word_18b` from bit 2, `att_common` from bit 3 and `out_mode` from bits 7:4.
- R7: While `att_common` is 1, `att_right` shows the active left code. While it is 0, `att_right` shows the active right code.
- R8: Once reset is released, a latch edge detected before LOCK_CYCLES (default 1024) system clocks have passed after the internal reset release is ignored. Later edges are accepted, and the port stays open until the next reset.
- R9: While `rst_n` is low, every output holds its default. Bits shifted and latch pulses during that time have no effect.
- R10: The defaults are: both attenuation codes 255; mute, de-emphasis, output disable and zero detect 0; `fmt_i2s`, `lr_swap`, `word_18b` and `att_common` 0; `out_mode` 4'b1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Control shift clock |
| ctl_dat | input | 1 | Control serial data |
| ctl_latch | input | 1 | Control latch, active on falling edge |
| att_left | output | 8 | Active left attenuation code |
| att_right | output | 8 | Right attenuation code after common selection |
| soft_mute | output | 1 | Soft mute request |
| deemph_sel | output | 2 | De-emphasis select |
| out_disable | output | 1 | Output forced to bipolar zero |
| zero_det_en | output | 1 | Zero-detect enable |
| fmt_i2s | output | 1 | Serial input uses I2S framing |
| lr_swap | output | 1 | Word-clock polarity inverted |
| word_18b | output | 1 | Input word length is 18 bits |
| att_common | output | 1 | Left code used for both channels |
| out_mode | output | 4 | Output channel routing mode |

## Verification
Two things can happen in the same cycle: storing a new pending code and the load transfer that publishes both channels. A write with the load bit set makes them coincide. The bench first stores a left code without load. It then writes a right code with load, and expects both active codes to change together on the third system clock after the latch falls. Its reference model, stepped on every clock, flags a channel that moves one cycle early or late, or that takes a stale code.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;

  typedef enum logic [1:0] {
    REG_ATT_L = 2'd0,
    REG_ATT_R = 2'd1,
    REG_MODE  = 2'd2,
    REG_FMT   = 2'd3
  } reg_sel_e;

  // Packed so that field order matches word bits 4:0
  typedef struct packed {
    logic       zd_en;
    logic       out_dis;
    logic [1:0] deemph;
    logic       mute;
  } mode_cfg_t;

  // Packed so that field order matches word bits 7:0
  typedef struct packed {
    logic [3:0] omode;
    logic       att_com;
    logic       w18;
    logic       lr_swap;
    logic       i2s;
  } fmt_cfg_t;

  localparam mode_cfg_t MODE_DEFAULT = '0;
  localparam fmt_cfg_t  FMT_DEFAULT  = '{omode: 4'b1001, att_com: 1'b0,
                                         w18: 1'b0, lr_swap: 1'b0, i2s: 1'b0};

endpackage

// File: rtl/tw_shift_in.sv
module tw_shift_in #(
  parameter int WORD_W = 16
) (
  input  logic              ctl_clk,
  input  logic              rst_n,
  input  logic              ctl_dat,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[WORD_W-2:0], ctl_dat};
  end

  // Port held cleared while reset is asserted
  always_ff @(posedge ctl_clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign word = sr_q;

endmodule

// File: rtl/tw_latch_sync.sv
module tw_latch_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_in,
  output logic rst_sn,
  output logic wr_stb
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LOCK_CYCLES);

  // Reset: asserted asynchronously, released after two clocks
  logic [1:0] rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  // Latch synchroniser plus one history stage for edge detection
  logic [SYNC_STAGES:0] ls_q;
  logic [SYNC_STAGES:0] ls_d;
  logic                 fall;

  always_comb begin
    ls_d = {ls_q[SYNC_STAGES-1:0], latch_in};
    fall = ls_q[SYNC_STAGES] & ~ls_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ls_q <= '1;
    else         ls_q <= ls_d;
  end

  // Post-reset lockout counter, saturates at the limit
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             ready;
  logic             cnt_en;

  always_comb begin
    ready  = (cnt_q == CNT_END);
    cnt_en = ~ready;
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wr_stb = fall & ready;

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stb |=> !wr_stb);

  assert_port_stays_open_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    ready |=> ready);

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_ctrl_pkg::*;
#(
  parameter int ATT_W    = 8,
  parameter int LOAD_BIT = 8,
  parameter int ADDR_LSB = 9,
  localparam int USED_W  = ADDR_LSB + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [USED_W-1:0]        word,
  output logic [1:0][ATT_W-1:0]    act_att,
  output mode_cfg_t                mode_cfg,
  output fmt_cfg_t                 fmt_cfg
);

  localparam int MODE_W = $bits(mode_cfg_t);
  localparam int FMT_W  = $bits(fmt_cfg_t);

  reg_sel_e              addr;
  logic [1:0][ATT_W-1:0] pend_q, pend_d;
  logic [1:0][ATT_W-1:0] act_q, act_d;
  mode_cfg_t             mode_q, mode_d;
  fmt_cfg_t              fmt_q, fmt_d;
  logic                  do_load;

  always_comb begin
    addr    = reg_sel_e'(word[ADDR_LSB +: 2]);
    pend_d  = pend_q;
    act_d   = act_q;
    mode_d  = mode_q;
    fmt_d   = fmt_q;
    do_load = 1'b0;
    if (wr_stb) begin
      unique case (addr)
        REG_ATT_L, REG_ATT_R: pend_d[word[ADDR_LSB]] = word[ATT_W-1:0];
        REG_MODE:             mode_d = mode_cfg_t'(word[MODE_W-1:0]);
        REG_FMT:              fmt_d  = fmt_cfg_t'(word[FMT_W-1:0]);
        default:              ;
      endcase
      do_load = ~word[ADDR_LSB+1] & word[LOAD_BIT];
    end
    if (do_load) act_d = pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '1;
      act_q  <= '1;
      mode_q <= MODE_DEFAULT;
      fmt_q  <= FMT_DEFAULT;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      mode_q <= mode_d;
      fmt_q  <= fmt_d;
    end
  end

  assign act_att  = act_q;
  assign mode_cfg = mode_q;
  assign fmt_cfg  = fmt_q;

  assert_hold_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(act_q) && $stable(mode_q) && $stable(fmt_q)));

  assert_active_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (word[ADDR_LSB+1] || !word[LOAD_BIT])) |=> $stable(act_q));

  assert_mode_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && word[ADDR_LSB +: 2] == 2'd2) |=> (mode_q == $past(word[MODE_W-1:0])));

  assert_fmt_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && word[ADDR_LSB +: 2] == 2'd3) |=> (fmt_q == $past(word[FMT_W-1:0])));

endmodule

// File: rtl/tw_ctrl_port.sv
module tw_ctrl_port
  import tw_ctrl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ATT_W       = 8,
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clk,
  input  logic             ctl_dat,
  input  logic             ctl_latch,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic             soft_mute,
  output logic [1:0]       deemph_sel,
  output logic             out_disable,
  output logic             zero_det_en,
  output logic             fmt_i2s,
  output logic             lr_swap,
  output logic             word_18b,
  output logic             att_common,
  output logic [3:0]       out_mode
);

  localparam int ADDR_LSB = 9;
  localparam int USED_W   = ADDR_LSB + 2;

  logic [WORD_W-1:0]     shift_word;
  logic                  rst_sn;
  logic                  wr_stb;
  logic [1:0][ATT_W-1:0] act_att;
  mode_cfg_t             mode_cfg;
  fmt_cfg_t              fmt_cfg;
  logic                  unused_rsv_bits;

  tw_shift_in #(.WORD_W(WORD_W)) i_shift (
    .ctl_clk (ctl_clk),
    .rst_n   (rst_n),
    .ctl_dat (ctl_dat),
    .word    (shift_word)
  );

  tw_latch_sync #(.SYNC_STAGES(SYNC_STAGES), .LOCK_CYCLES(LOCK_CYCLES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_in (ctl_latch),
    .rst_sn   (rst_sn),
    .wr_stb   (wr_stb)
  );

  // Reserved bits carry no function
  assign unused_rsv_bits = ^shift_word[WORD_W-1:USED_W];

  tw_reg_bank #(.ATT_W(ATT_W), .LOAD_BIT(8), .ADDR_LSB(ADDR_LSB)) i_bank (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_stb   (wr_stb),
    .word     (shift_word[USED_W-1:0]),
    .act_att  (act_att),
    .mode_cfg (mode_cfg),
    .fmt_cfg  (fmt_cfg)
  );

  assign att_left    = act_att[0];
  assign att_right   = fmt_cfg.att_com ? act_att[0] : act_att[1];
  assign soft_mute   = mode_cfg.mute;
  assign deemph_sel  = mode_cfg.deemph;
  assign out_disable = mode_cfg.out_dis;
  assign zero_det_en = mode_cfg.zd_en;
  assign fmt_i2s     = fmt_cfg.i2s;
  assign lr_swap     = fmt_cfg.lr_swap;
  assign word_18b    = fmt_cfg.w18;
  assign att_common  = fmt_cfg.att_com;
  assign out_mode    = fmt_cfg.omode;

endmodule

// File: tb/test_tw_ctrl_port.sv
module test_tw_ctrl_port;

  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ctl_clk = 1'b0;
  logic ctl_dat = 1'b0;
  logic ctl_latch = 1'b1;
  logic [7:0] att_left, att_right;
  logic soft_mute, out_disable, zero_det_en, fmt_i2s, lr_swap, word_18b, att_common;
  logic [1:0] deemph_sel;
  logic [3:0] out_mode;

  tw_ctrl_port i_tw_ctrl_port (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_dat(ctl_dat), .ctl_latch(ctl_latch),
    .att_left(att_left), .att_right(att_right), .soft_mute(soft_mute),
    .deemph_sel(deemph_sel), .out_disable(out_disable), .zero_det_en(zero_det_en),
    .fmt_i2s(fmt_i2s), .lr_swap(lr_swap), .word_18b(word_18b),
    .att_common(att_common), .out_mode(out_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int since_rel = 0;
  int cycles = 0;
  bit check_en = 0;
  bit shq[$];
  int exp_pend[2];
  int exp_act[2];
  int exp_mode;
  int exp_fmt;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_defaults();
    exp_pend[0] = 255; exp_pend[1] = 255;
    exp_act[0]  = 255; exp_act[1]  = 255;
    exp_mode = 0;
    exp_fmt  = 'h90;
  endfunction

  function automatic int model_word();
    int w = 0;
    for (int i = 0; i < 16; i++) begin
      int idx = shq.size() - 16 + i;
      w = (w << 1) | ((idx >= 0) ? int'(shq[idx]) : 0);
    end
    return w;
  endfunction

  function automatic void model_apply(int w);
    int a = (w >> 9) & 3;
    case (a)
      0, 1: exp_pend[a] = w & 'hFF;
      2: exp_mode = w & 'h1F;
      default: exp_fmt = w & 'hFF;
    endcase
    if (a < 2 && ((w >> 8) & 1) == 1) begin
      exp_act[0] = exp_pend[0];
      exp_act[1] = exp_pend[1];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) since_rel = 0;
    else        since_rel++;
  end

  // Cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    cycles++;
    if (check_en) begin
      check("R4 att_left", int'(att_left), exp_act[0]);
      check("R7 att_right", int'(att_right), ((exp_fmt >> 3) & 1) ? exp_act[0] : exp_act[1]);
      check("R5 mode", int'({zero_det_en, out_disable, deemph_sel, soft_mute}), exp_mode);
      check("R6 format", int'({out_mode, att_common, word_18b, lr_swap, fmt_i2s}), exp_fmt);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic shift_bits(int n, longint v);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_dat = v[i];
      #3 ctl_clk = 1'b1;
      if (rst_n) begin
        shq.push_back(v[i]);
        if (shq.size() > 32) void'(shq.pop_front());
      end
      #3 ctl_clk = 1'b0;
      #1;
    end
  endtask

  task automatic latch_pulse(int low_cycles);
    bit accept;
    @(posedge clk);
    #1 ctl_latch = 1'b0;
    accept = rst_n && (since_rel > LOCK + 40);
    repeat (3) @(posedge clk);
    if (accept) model_apply(model_word());
    repeat (low_cycles) @(posedge clk);
    #1 ctl_latch = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic write_word(int w);
    shift_bits(16, w);
    latch_pulse(2);
  endtask

  initial begin
    model_defaults();
    #1 rst_n = 1'b0;
    check_en = 1;
    repeat (3) @(posedge clk);
    #1;
    // R10, R9: defaults while held in reset
    check("R10 out_mode default", int'(out_mode), 9);
    check("R9 att_left in reset", int'(att_left), 255);
    #1 rst_n = 1'b1;

    // R8: write inside the lockout window is ignored
    repeat (20) @(posedge clk);
    write_word('h0401);
    check("R8 mute after early write", int'(soft_mute), 0);

    while (since_rel < LOCK + 80) @(posedge clk);

    // R5: mode register
    write_word('h041D);
    check("R5 deemph_sel", int'(deemph_sel), 2);
    check("R8 write accepted after lockout", int'(soft_mute), 1);

    // R2, R6: format with reserved bits set
    write_word('hF800 | (3 << 9) | 'h65);
    check("R2 reserved bits ignored", int'(out_mode), 6);
    check("R6 word_18b", int'(word_18b), 1);

    // R4: pending only, then load publishes both channels together
    write_word('h0040);
    check("R4 left held without load", int'(att_left), 255);
    write_word('h0200 | 'h100 | 'h20);
    check("R4 left after load", int'(att_left), 'h40);
    check("R4 right after load", int'(att_right), 'h20);

    // R7: common attenuation
    write_word('h0600 | 'h98);
    check("R7 right follows left", int'(att_right), 'h40);
    write_word('h0600 | 'h90);
    check("R7 right own code", int'(att_right), 'h20);

    // R1: extra leading bits discarded
    shift_bits(20, (longint'('hF) << 16) | 'h0402);
    latch_pulse(2);
    check("R1 last 16 bits used", int'({deemph_sel, soft_mute}), 2);

    // R3: exact latency and one update per long low pulse
    shift_bits(16, 'h0401);
    @(posedge clk);
    #1 ctl_latch = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 not yet updated", int'(soft_mute), 0);
    @(posedge clk);
    model_apply(model_word());
    @(negedge clk);
    check("R3 updated on third edge", int'(soft_mute), 1);
    shift_bits(16, 'h0400);
    repeat (10) @(posedge clk);
    check("R3 no second update while low", int'(soft_mute), 1);
    #1 ctl_latch = 1'b1;
    repeat (4) @(posedge clk);

    // R9: reset mid-run, activity during reset has no effect
    @(posedge clk);
    #1 rst_n = 1'b0;
    model_defaults();
    shq.delete();
    shift_bits(16, 'h041F);
    latch_pulse(4);
    check("R9 mode after reset", int'(soft_mute), 0);
    check("R10 att_right default", int'(att_right), 255);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    check("R9 out_mode after release", int'(out_mode), 9);

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule